// File: doc/BRIEF.md
# Dual Auto-Negotiation Bridge Controller

This controller sits between two negotiation engines. One faces the host over a serial link that exchanges configuration words. The other negotiates with the partner at the far end of the line. The controller keeps the host from finishing its negotiation until the line link is up. Until then it sends the host an empty advertisement and no acknowledge. It stores the abilities the host announces in its configuration words, and the line engine uses them at its next restart. Once the line link is up, the controller passes the line partner's abilities back to the host together with an acknowledge.

Some hosts have negotiation switched off and send only idles. For these the controller has a timed fallback. After the line link comes up, an acknowledge window opens. If the window runs for a full `WIN_CYC` cycles with nothing but idles from the host, the controller enters bypass and enables traffic. The window length is a cycle count, sized for 200 ms in the default build. Traffic is enabled only when both sides are up, either through completed host negotiation or through bypass. Losing either link sends the controller back to a line restart, as does any of the three restart commands.

Configuration words arrive as a valid-qualified stream with no ready signal. The controller takes every word presented while the valid input is high and never applies back-pressure. All other pins are plain levels or single-cycle pulses.

Top module: `dual_neg_bridge`

## Requirements
- R1: While the line link is down, and in the cycle of any restart, `host_adv` is all zero and `host_ack` and `data_en` are 0. This holds even while configuration words are arriving.
- R2: The abilities of every configuration word are stored. `line_adv` changes only in the cycle in which `line_restart` is high, and it then shows the most recently stored abilities. While the line link is down, a word whose abilities differ from `line_adv` causes a restart on the next cycle. A word equal to `line_adv` causes none.
- R3: One cycle after `line_link_up` is sampled high with the line down, `host_adv` equals `line_partner_abil` and `host_ack` is 1.
- R4: While the acknowledge is given, `host_an_done` together with `host_sync` raises `data_en` on the next cycle with `bypass_active` at 0.
- R5: With bypass allowed, `bypass_active` and `data_en` rise exactly `WIN_CYC` cycles after the acknowledge first shows. Every one of those cycles must have `host_idle` and `host_sync` at 1 and no configuration word. Any other cycle restarts the count.
- R6: While `bypass_en` is 0, bypass is never entered. The acknowledge stays up and host negotiation can still complete.
- R7: Loss of `line_link_up`, or loss of `host_sync` while traffic is enabled, gives a restart pulse on the next cycle and returns the outputs to the R1 state.
- R8: A one-cycle pulse on `sw_reset`, `an_restart` or `pwr_up_cmd` gives exactly one restart pulse on the next cycle. `sw_reset` also returns the stored abilities to `DEF_ABIL`, so `line_adv` equals `DEF_ABIL` at that restart.
- R9: `line_restart` is high for exactly one cycle per restart event. The first such cycle is the one right after reset release, with `line_adv` equal to `DEF_ABIL`.
- R10: A configuration word received in bypass clears `bypass_active` and `data_en` on the next cycle and reopens the acknowledge window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (power-up reset) |
| host_cfg_valid | input | 1 | A configuration word is present this cycle |
| host_cfg_abil | input | ABIL_W | Ability field of the configuration word |
| host_idle | input | 1 | Host is sending idles this cycle |
| host_sync | input | 1 | Host serial link is synchronised |
| host_an_done | input | 1 | Host-side negotiation engine reports completion |
| line_link_up | input | 1 | Line link is up |
| line_partner_abil | input | ABIL_W | Abilities learned from the line partner |
| sw_reset | input | 1 | Software reset pulse |
| an_restart | input | 1 | Negotiation restart command pulse |
| pwr_up_cmd | input | 1 | Software power-up command pulse |
| bypass_en | input | 1 | 1 allows the idle-only bypass (default setting) |
| host_adv | output | ABIL_W | Abilities advertised toward the host |
| host_ack | output | 1 | Acknowledge toward the host |
| line_adv | output | ABIL_W | Advertisement used by the line engine |
| line_restart | output | 1 | One-cycle pulse restarting line negotiation |
| bypass_active | output | 1 | Bypass mode in force |
| data_en | output | 1 | Traffic enabled |

## Verification
The bench builds the block with `WIN_CYC` = 20, `ABIL_W` = 16 and `DEF_ABIL` = 16'h01A0. The short window puts the exact bypass-entry cycle within reach. It also lets the bench restart the window with a mid-window configuration word and see the entry move by the matching number of cycles. The distinct default abilities let the bench tell a software-reset restart from a plain restart by the value of `line_adv`.

// File: rtl/dnb_pkg.sv
package dnb_pkg;

  typedef enum logic [2:0] {
    ST_RESET      = 3'd0,
    ST_WAIT_LINE  = 3'd1,
    ST_WAIT_HOST  = 3'd2,
    ST_BYP_TIMER  = 3'd3,
    ST_BYPASS     = 3'd4,
    ST_LINK_OK    = 3'd5
  } dnb_state_e;

  function automatic logic ack_state(input dnb_state_e s);
    return (s == ST_WAIT_HOST) || (s == ST_BYP_TIMER) || (s == ST_LINK_OK);
  endfunction

  function automatic logic traffic_state(input dnb_state_e s);
    return (s == ST_LINK_OK) || (s == ST_BYPASS);
  endfunction

endpackage

// File: rtl/dnb_abil_store.sv
module dnb_abil_store #(
  parameter int unsigned   ABIL_W   = 16,
  parameter logic [ABIL_W-1:0] DEF_ABIL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [ABIL_W-1:0] cfg_abil,
  input  logic              sw_clear,
  input  logic              snap,
  output logic [ABIL_W-1:0] line_adv
);

  logic [ABIL_W-1:0] stored_q;
  logic [ABIL_W-1:0] stored_d;
  logic [ABIL_W-1:0] adv_q;

  // newest abilities, including a word or a clear arriving this cycle
  always_comb begin
    if (sw_clear)       stored_d = DEF_ABIL;
    else if (cfg_valid) stored_d = cfg_abil;
    else                stored_d = stored_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stored_q <= DEF_ABIL;
      adv_q    <= DEF_ABIL;
    end else begin
      stored_q <= stored_d;
      if (snap) adv_q <= stored_d;
    end
  end

  assign line_adv = adv_q;

  // R8: a software clear always leaves the default behind
  p_clear_default_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clear && snap) |=> (line_adv == DEF_ABIL));

endmodule

// File: rtl/dnb_window.sv
module dnb_window #(
  parameter int unsigned WIN_CYC = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic qual,
  output logic expired
);

  localparam int unsigned CW = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || !qual) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign expired = run && qual && (cnt_q == LAST);

  // R5: a disqualifying cycle always restarts the window
  p_win_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!qual) |=> (!expired || (WIN_CYC < 2)));

endmodule

// File: rtl/dnb_fsm.sv
module dnb_fsm
  import dnb_pkg::*;
#(
  parameter int unsigned ABIL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_req,
  input  logic              host_cfg_valid,
  input  logic [ABIL_W-1:0] host_cfg_abil,
  input  logic              host_idle,
  input  logic              host_sync,
  input  logic              host_an_done,
  input  logic              line_link_up,
  input  logic [ABIL_W-1:0] line_partner_abil,
  input  logic [ABIL_W-1:0] line_adv,
  input  logic              bypass_en,
  input  logic              win_expired,
  output logic              win_run,
  output logic              win_qual,
  output logic              snap,
  output logic [ABIL_W-1:0] host_adv,
  output logic              host_ack,
  output logic              line_restart,
  output logic              bypass_active,
  output logic              data_en
);

  dnb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (restart_req) begin
      state_d = ST_RESET;
    end else begin
      unique case (state_q)
        ST_RESET: state_d = ST_WAIT_LINE;
        ST_WAIT_LINE: begin
          if (host_cfg_valid && (host_cfg_abil != line_adv))
            state_d = ST_RESET;
          else if (line_link_up)
            state_d = bypass_en ? ST_BYP_TIMER : ST_WAIT_HOST;
        end
        ST_WAIT_HOST: begin
          if (!line_link_up)                   state_d = ST_RESET;
          else if (host_an_done && host_sync)  state_d = ST_LINK_OK;
          else if (bypass_en)                  state_d = ST_BYP_TIMER;
        end
        ST_BYP_TIMER: begin
          if (!line_link_up)                   state_d = ST_RESET;
          else if (host_an_done && host_sync)  state_d = ST_LINK_OK;
          else if (!bypass_en)                 state_d = ST_WAIT_HOST;
          else if (win_expired)                state_d = ST_BYPASS;
        end
        ST_BYPASS: begin
          if (!line_link_up || !host_sync)     state_d = ST_RESET;
          else if (host_cfg_valid)             state_d = ST_BYP_TIMER;
        end
        ST_LINK_OK: begin
          if (!line_link_up || !host_sync)     state_d = ST_RESET;
        end
        default: state_d = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_RESET;
    else        state_q <= state_d;
  end

  assign snap          = (state_d == ST_RESET);
  assign win_run       = (state_q == ST_BYP_TIMER);
  assign win_qual      = host_idle && host_sync && !host_cfg_valid;
  assign host_ack      = ack_state(state_q);
  assign host_adv      = (ack_state(state_q) || state_q == ST_BYPASS) ? line_partner_abil : '0;
  assign line_restart  = (state_q == ST_RESET);
  assign bypass_active = (state_q == ST_BYPASS);
  assign data_en       = traffic_state(state_q);

  // R1: a down line withholds acknowledge and abilities on the next cycle
  p_hold_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_link_up) |=> (!host_ack && host_adv == '0 && !data_en));

  // R9: the restart pulse lasts one cycle unless a new request arrives
  p_restart_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (line_restart && !restart_req &&
     !(host_cfg_valid && host_cfg_abil != line_adv)) |=> !line_restart);

  // R6: no bypass entry while it is disallowed
  p_no_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass_en && !bypass_active) |=> !bypass_active);

  // R10: a configuration word ends bypass
  p_cfg_leaves_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_active && host_cfg_valid) |=> !bypass_active);

endmodule

// File: rtl/dual_neg_bridge.sv
module dual_neg_bridge #(
  parameter int unsigned       ABIL_W   = 16,
  parameter int unsigned       WIN_CYC  = 25_000_000,
  parameter logic [ABIL_W-1:0] DEF_ABIL = 16'h01A0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cfg_valid,
  input  logic [ABIL_W-1:0] host_cfg_abil,
  input  logic              host_idle,
  input  logic              host_sync,
  input  logic              host_an_done,
  input  logic              line_link_up,
  input  logic [ABIL_W-1:0] line_partner_abil,
  input  logic              sw_reset,
  input  logic              an_restart,
  input  logic              pwr_up_cmd,
  input  logic              bypass_en,
  output logic [ABIL_W-1:0] host_adv,
  output logic              host_ack,
  output logic [ABIL_W-1:0] line_adv,
  output logic              line_restart,
  output logic              bypass_active,
  output logic              data_en
);

  logic restart_req;
  logic snap;
  logic win_run, win_qual, win_expired;

  assign restart_req = sw_reset || an_restart || pwr_up_cmd;

  dnb_abil_store #(.ABIL_W(ABIL_W), .DEF_ABIL(DEF_ABIL)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_valid(host_cfg_valid),
    .cfg_abil (host_cfg_abil),
    .sw_clear (sw_reset),
    .snap     (snap),
    .line_adv (line_adv)
  );

  dnb_window #(.WIN_CYC(WIN_CYC)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (win_run),
    .qual   (win_qual),
    .expired(win_expired)
  );

  dnb_fsm #(.ABIL_W(ABIL_W)) u_fsm (
    .clk              (clk),
    .rst_n            (rst_n),
    .restart_req      (restart_req),
    .host_cfg_valid   (host_cfg_valid),
    .host_cfg_abil    (host_cfg_abil),
    .host_idle        (host_idle),
    .host_sync        (host_sync),
    .host_an_done     (host_an_done),
    .line_link_up     (line_link_up),
    .line_partner_abil(line_partner_abil),
    .line_adv         (line_adv),
    .bypass_en        (bypass_en),
    .win_expired      (win_expired),
    .win_run          (win_run),
    .win_qual         (win_qual),
    .snap             (snap),
    .host_adv         (host_adv),
    .host_ack         (host_ack),
    .line_restart     (line_restart),
    .bypass_active    (bypass_active),
    .data_en          (data_en)
  );

  // R2: the line advertisement moves only together with a restart pulse
  p_adv_on_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_adv) |-> line_restart);

  // R4: traffic needs the line link in the previous cycle
  p_traffic_links_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_en |-> $past(line_link_up));

  // R5: bypass is entered only after an idle-only cycle
  p_bypass_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bypass_active) |-> ($past(host_idle) && !$past(host_cfg_valid)));

  // R7: losing the line while passing traffic restarts at once
  p_loss_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_en && !line_link_up) |=> line_restart);

endmodule

// File: tb/tb_dual_neg_bridge.sv
module tb_dual_neg_bridge;

  localparam int unsigned ABIL_W = 16;
  localparam int unsigned WIN    = 20;
  localparam logic [15:0] DEF    = 16'h01A0;
  localparam logic [15:0] ABIL_A = 16'h0060;
  localparam logic [15:0] ABIL_P = 16'h4021;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_cfg_valid = 1'b0;
  logic [ABIL_W-1:0] host_cfg_abil = '0;
  logic host_idle = 1'b0, host_sync = 1'b0, host_an_done = 1'b0;
  logic line_link_up = 1'b0;
  logic [ABIL_W-1:0] line_partner_abil = ABIL_P;
  logic sw_reset = 1'b0, an_restart = 1'b0, pwr_up_cmd = 1'b0;
  logic bypass_en = 1'b1;
  logic [ABIL_W-1:0] host_adv, line_adv;
  logic host_ack, line_restart, bypass_active, data_en;

  int checks = 0;
  int errors = 0;
  int rcnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_neg_bridge #(.ABIL_W(ABIL_W), .WIN_CYC(WIN), .DEF_ABIL(DEF)) dut (
    .clk(clk), .rst_n(rst_n),
    .host_cfg_valid(host_cfg_valid), .host_cfg_abil(host_cfg_abil),
    .host_idle(host_idle), .host_sync(host_sync), .host_an_done(host_an_done),
    .line_link_up(line_link_up), .line_partner_abil(line_partner_abil),
    .sw_reset(sw_reset), .an_restart(an_restart), .pwr_up_cmd(pwr_up_cmd),
    .bypass_en(bypass_en),
    .host_adv(host_adv), .host_ack(host_ack), .line_adv(line_adv),
    .line_restart(line_restart), .bypass_active(bypass_active), .data_en(data_en)
  );

  always @(negedge clk) if (rst_n && line_restart) rcnt++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    tick(4);
    rst_n = 1'b1;
    #1;
    chk(line_restart == 1'b1, "R9 restart after reset", 32'(line_restart), 1);
    chk(line_adv == DEF, "R9 default line adv", 32'(line_adv), 32'(DEF));
    chk(!host_ack && host_adv == '0 && !data_en, "R1 reset outputs",
        {host_adv, 15'd0, host_ack}, 0);
    tick(1);
    chk(line_restart == 1'b0, "R9 single pulse", 32'(line_restart), 0);
  endtask

  task automatic t_capture;
    int r0;
    host_cfg_valid = 1'b1; host_cfg_abil = ABIL_A;
    tick(1);
    chk(line_restart == 1'b1, "R2 changed word restarts", 32'(line_restart), 1);
    chk(line_adv == ABIL_A, "R2 line adv takes word", 32'(line_adv), 32'(ABIL_A));
    host_cfg_valid = 1'b0;
    tick(1);
    r0 = rcnt;
    host_cfg_valid = 1'b1;
    tick(3);
    chk(!host_ack && host_adv == '0, "R1 no ack during words",
        {host_adv, 15'd0, host_ack}, 0);
    host_cfg_valid = 1'b0;
    tick(2);
    chk(rcnt == r0, "R2 equal word no restart", 32'(rcnt), 32'(r0));
  endtask

  task automatic t_handshake;
    host_idle = 1'b0; host_sync = 1'b1; line_link_up = 1'b1;
    tick(1);
    chk(host_ack && host_adv == ABIL_P, "R3 ack with partner abil",
        {host_adv, 15'd0, host_ack}, {ABIL_P, 16'd1});
    chk(!data_en, "R3 no traffic before host done", 32'(data_en), 0);
    host_an_done = 1'b1;
    tick(1);
    chk(data_en && !bypass_active, "R4 traffic after host done",
        {data_en, bypass_active}, 2'b10);
  endtask

  task automatic t_line_loss;
    line_link_up = 1'b0;
    tick(1);
    host_an_done = 1'b0;
    chk(line_restart, "R7 restart on line loss", 32'(line_restart), 1);
    chk(!host_ack && host_adv == '0 && !data_en, "R7 back to withhold",
        {host_adv, 15'd0, host_ack}, 0);
    chk(line_adv == ABIL_A, "R2 restart uses host abil", 32'(line_adv), 32'(ABIL_A));
    tick(2);
  endtask

  task automatic t_bypass;
    host_idle = 1'b1; line_link_up = 1'b1;
    tick(1);
    chk(host_ack, "R5 window opens with ack", 32'(host_ack), 1);
    for (int k = 0; k <= int'(WIN) + 6; k++) begin
      if (k == 5) host_cfg_valid = 1'b1;
      if (k == 6) host_cfg_valid = 1'b0;
      if (k == int'(WIN))
        chk(!bypass_active, "R5 window restarted by word", 32'(bypass_active), 0);
      if (k == int'(WIN) + 5)
        chk(!bypass_active, "R5 no early bypass", 32'(bypass_active), 0);
      if (k == int'(WIN) + 6)
        chk(bypass_active && data_en, "R5 bypass at window end",
            {bypass_active, data_en}, 2'b11);
      if (k < int'(WIN) + 6) tick(1);
    end
  endtask

  task automatic t_bypass_cfg;
    host_cfg_valid = 1'b1;
    tick(1);
    host_cfg_valid = 1'b0;
    chk(!bypass_active && !data_en && host_ack, "R10 word leaves bypass",
        {bypass_active, data_en, host_ack}, 3'b001);
    tick(WIN);
    chk(bypass_active, "R10 bypass again after window", 32'(bypass_active), 1);
    host_sync = 1'b0;
    tick(1);
    chk(line_restart && !data_en, "R7 restart on host sync loss",
        {line_restart, data_en}, 2'b10);
    host_sync = 1'b1;
    tick(2);
  endtask

  task automatic t_no_bypass;
    bit seen = 1'b0;
    bypass_en = 1'b0;
    for (int i = 0; i < 3 * int'(WIN); i++) begin
      tick(1);
      if (bypass_active) seen = 1'b1;
    end
    chk(!seen && host_ack, "R6 no bypass when disabled", {seen, host_ack}, 2'b01);
    host_an_done = 1'b1;
    tick(1);
    chk(data_en && !bypass_active, "R6 host negotiation still completes",
        {data_en, bypass_active}, 2'b10);
    host_an_done = 1'b0;
    bypass_en = 1'b1;
  endtask

  task automatic t_triggers;
    int r0;
    for (int t = 0; t < 3; t++) begin
      r0 = rcnt;
      an_restart = (t == 0); pwr_up_cmd = (t == 1); sw_reset = (t == 2);
      tick(1);
      an_restart = 1'b0; pwr_up_cmd = 1'b0; sw_reset = 1'b0;
      chk(line_restart && !data_en, "R8 trigger restarts",
          {line_restart, data_en}, 2'b10);
      if (t == 2)
        chk(line_adv == DEF, "R8 sw reset restores default", 32'(line_adv), 32'(DEF));
      else
        chk(line_adv == ABIL_A, "R8 plain restart keeps abil", 32'(line_adv), 32'(ABIL_A));
      tick(1);
      chk(!line_restart, "R9 pulse one cycle", 32'(line_restart), 0);
      chk(rcnt == r0 + 1, "R8 exactly one restart", 32'(rcnt), 32'(r0 + 1));
      tick(3);
    end
  endtask

  initial begin
    t_reset();
    t_capture();
    t_handshake();
    t_line_loss();
    t_bypass();
    t_bypass_cfg();
    t_no_bypass();
    t_triggers();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule